// File: doc/BRIEF.md
# Heartbeat Watchdog with Disable-on-Float

This block supervises a processor by watching a heartbeat line that software toggles. Every high-going or low-going change on that line restarts a countdown. If the countdown runs out before the next change arrives, the active-low output `wdogN` drops and stays low until the heartbeat moves again. The timeout is set by two parameters: a prescaler that divides the clock into ticks, and the number of ticks that make up one timeout.

Two digital flags stop the timer. One reports that the heartbeat pin is floating or three-stated. The other reports that the system is held in reset. While either flag is set, the timer is cleared, does not count and ignores heartbeat changes, and the output stays high. A supply-good flag acts on the output without passing through any register. A low supply drives `wdogN` low at once, and the output is released as soon as the supply recovers, with no minimum low time. Pin-float detection and analog sensing lie outside the block and reach it only as these flags.

Top module: `hbwd_top`

## Requirements
- R1: After a heartbeat change is registered, SYNC_STAGES+1 clock edges after the input moves, `wdogN` goes low exactly TIMEOUT_TICKS*TICK_DIV clock edges later if no further change occurs, and not earlier.
- R2: Once `wdogN` is low after a timeout, it stays low for as long as the heartbeat does not change, and goes high again on the first change that is registered.
- R3: While `hbFloating` is 1, the timer is cleared and does not count, heartbeat changes have no effect, and `wdogN` is high whenever `supplyOk` is 1.
- R4: While `sysReset` is 1, the timer is cleared and does not count, heartbeat changes have no effect, and `wdogN` is high whenever `supplyOk` is 1.
- R5: Counting starts only at the first heartbeat change seen after both disable flags are 0. Rising and falling changes both count, and a heartbeat pulse one clock period wide is detected.
- R6: Each registered heartbeat change reloads the timer, so the timeout of R1 is measured from the most recent change.
- R7: When `supplyOk` is 0, `wdogN` is 0 in the same cycle. When `supplyOk` returns to 1, `wdogN` follows in the same cycle unless a timeout is pending, so a supply dip of any length shows on the output.
- R8: While `rstN` is 0, the timer is idle and `wdogN` equals `supplyOk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| heartbeatIn | input | 1 | Processor heartbeat, asynchronous |
| hbFloating | input | 1 | 1 when the heartbeat pin is floating or three-stated |
| sysReset | input | 1 | 1 while the system reset is asserted |
| supplyOk | input | 1 | 1 while the supply is above threshold |
| wdogN | output | 1 | Active-low watchdog output, a level signal |

## Verification
The assertions assume that `hbFloating`, `sysReset` and `supplyOk` are already synchronous to `clk`, and that every heartbeat level lasts at least one clock period. Under that assumption no change can fall between two samples. The bench changes every input just after a falling clock edge and holds each heartbeat level for at least one full period. The shortest case is a pulse exactly one period wide, which is enough to exercise detection of both edge polarities.

// File: rtl/hbwd_pkg.sv
package hbwd_pkg;

  typedef struct packed {
    logic clear;   // zero prescaler and tick counter
    logic load;    // restart countdown on a heartbeat change
    logic count;   // advance prescaler this cycle
  } hbwdStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_EXPIRED = 2'd2
  } hbwdState_e;

endpackage

// File: rtl/hbwd_datapath.sv
module hbwd_datapath
  import hbwd_pkg::*;
#(
  parameter int TICK_DIV      = 1000,
  parameter int TIMEOUT_TICKS = 1600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        heartbeatIn,
  input  hbwdStrobe_t strobes,
  output logic        edgeSeen,
  output logic        timeoutHit
);

  localparam int PRE_W  = $clog2(TICK_DIV + 1);
  localparam int TICK_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TICK_DIV - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TIMEOUT_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   hbSampled;
  logic                   hbPrev;

  // Synchronizer: a shift chain, or a single flop when one stage is asked for
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], heartbeatIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= heartbeatIn;
      end
    end
  endgenerate

  assign hbSampled = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hbPrev <= 1'b0;
    else       hbPrev <= hbSampled;
  end

  // Either polarity of change counts as activity
  assign edgeSeen = hbSampled ^ hbPrev;

  logic [PRE_W-1:0]  preCnt;
  logic [TICK_W-1:0] tickCnt;
  logic              preWrap;
  logic              tickLast;

  assign preWrap  = (preCnt == PRE_LAST);
  assign tickLast = (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobes.clear || strobes.load) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobes.count) begin
      if (preWrap) begin
        preCnt  <= '0;
        tickCnt <= tickLast ? '0 : tickCnt + 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
    end
  end

  assign timeoutHit = strobes.count & preWrap & tickLast;

  AST_LOAD_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (preCnt == '0 && tickCnt == '0)) else $error("load did not zero counters"); // R6

  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clear && $past(strobes.clear)) |-> (preCnt == '0 && tickCnt == '0)) else $error("counters moved while cleared"); // R3

endmodule

// File: rtl/hbwd_ctrl.sv
module hbwd_ctrl
  import hbwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hbFloating,
  input  logic        sysReset,
  input  logic        edgeSeen,
  input  logic        timeoutHit,
  output hbwdStrobe_t strobes,
  output logic        expired
);

  hbwdState_e state;
  hbwdState_e stateNext;
  logic       disabled;

  assign disabled = hbFloating | sysReset;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    if (disabled) begin
      stateNext     = ST_IDLE;
      strobes.clear = 1'b1;
    end else if (edgeSeen) begin
      stateNext    = ST_RUN;
      strobes.load = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE:    strobes.clear = 1'b1;
        ST_RUN: begin
          strobes.count = 1'b1;
          if (timeoutHit) stateNext = ST_EXPIRED;
        end
        ST_EXPIRED: strobes.clear = 1'b1;
        default:    stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign expired = (state == ST_EXPIRED);

  AST_FLOAT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    hbFloating |=> (state == ST_IDLE)) else $error("floating input did not stop timer"); // R3

  AST_SYSRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> (state == ST_IDLE)) else $error("system reset did not stop timer"); // R4

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSeen && !disabled) |=> (state == ST_RUN)) else $error("edge did not restart countdown"); // R6

  AST_EXPIRE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !edgeSeen && !disabled) |=> expired) else $error("expired state released without edge"); // R2

  AST_TIMEOUT_EXPIRES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && timeoutHit && !edgeSeen && !disabled) |=> expired) else $error("timeout not taken"); // R1

  AST_IDLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !edgeSeen) |=> (state == ST_IDLE)) else $error("started without edge"); // R5

endmodule

// File: rtl/hbwd_top.sv
module hbwd_top
  import hbwd_pkg::*;
#(
  parameter int TICK_DIV      = 1000,
  parameter int TIMEOUT_TICKS = 1600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic heartbeatIn,
  input  logic hbFloating,
  input  logic sysReset,
  input  logic supplyOk,
  output logic wdogN
);

  hbwdStrobe_t strobes;
  logic        edgeSeen;
  logic        timeoutHit;
  logic        expired;

  hbwd_datapath #(
    .TICK_DIV     (TICK_DIV),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .heartbeatIn(heartbeatIn),
    .strobes    (strobes),
    .edgeSeen   (edgeSeen),
    .timeoutHit (timeoutHit)
  );

  hbwd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hbFloating(hbFloating),
    .sysReset  (sysReset),
    .edgeSeen  (edgeSeen),
    .timeoutHit(timeoutHit),
    .strobes   (strobes),
    .expired   (expired)
  );

  // Supply acts on the output with no register in the path
  assign wdogN = supplyOk & ~expired;

  AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> !wdogN) else $error("output high with supply low"); // R7

  AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((hbFloating || sysReset) && supplyOk) |=> (wdogN || !supplyOk)) else $error("output low while disabled"); // R3

endmodule

// File: tb/hbwd_top_bench.sv
module hbwd_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int TICKS = 5;
  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + 1 + DIV * TICKS;   // input change to output low

  typedef struct packed {
    logic       flt;
    logic       rst;
    logic       sup;
    logic       tog;
    logic [7:0] waitCyc;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b1,1'b1, 8'(LAT-1), 1'b1, 4'd1},  // 0  R1 rising change, just before timeout
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,      1'b0, 4'd1},  // 1  R1 timeout reached
    '{1'b0,1'b0,1'b1,1'b0, 8'd30,     1'b0, 4'd2},  // 2  R2 held low
    '{1'b0,1'b0,1'b1,1'b1, 8'd3,      1'b1, 4'd2},  // 3  R2 falling change releases
    '{1'b0,1'b0,1'b1,1'b0, 8'd12,     1'b1, 4'd6},  // 4  R6 mid count
    '{1'b0,1'b0,1'b1,1'b1, 8'(LAT-1), 1'b1, 4'd6},  // 5  R6 reload kept it high
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,      1'b0, 4'd6},  // 6  R6 timeout from reload
    '{1'b0,1'b0,1'b0,1'b1, 8'd3,      1'b0, 4'd7},  // 7  R7 supply low forces low
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,      1'b1, 4'd7},  // 8  R7 supply back
    '{1'b0,1'b0,1'b0,1'b0, 8'd1,      1'b0, 4'd7},  // 9  R7 one cycle dip
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,      1'b1, 4'd7},  // 10 R7 released at once
    '{1'b1,1'b0,1'b1,1'b0, 8'd40,     1'b1, 4'd3},  // 11 R3 floating stops count
    '{1'b1,1'b0,1'b1,1'b1, 8'd40,     1'b1, 4'd3},  // 12 R3 change ignored
    '{1'b0,1'b0,1'b1,1'b0, 8'd40,     1'b1, 4'd5},  // 13 R5 no change, no start
    '{1'b0,1'b0,1'b1,1'b1, 8'(LAT-1), 1'b1, 4'd5},  // 14 R5 first change starts
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,      1'b0, 4'd5},  // 15 R5 timeout
    '{1'b0,1'b1,1'b1,1'b0, 8'd3,      1'b1, 4'd4},  // 16 R4 reset clears expiry
    '{1'b0,1'b1,1'b1,1'b1, 8'd40,     1'b1, 4'd4},  // 17 R4 change ignored
    '{1'b0,1'b0,1'b1,1'b0, 8'd40,     1'b1, 4'd4},  // 18 R4 idle after release
    '{1'b0,1'b0,1'b1,1'b1, 8'(LAT),   1'b0, 4'd4},  // 19 R4 counts after change
    '{1'b0,1'b0,1'b1,1'b1, 8'd10,     1'b1, 4'd3},  // 20 R3 counting
    '{1'b1,1'b0,1'b1,1'b0, 8'd30,     1'b1, 4'd3},  // 21 R3 float mid count
    '{1'b0,1'b0,1'b1,1'b1, 8'(LAT-1), 1'b1, 4'd3},  // 22 R3 fresh count after float
    '{1'b0,1'b0,1'b1,1'b0, 8'd1,      1'b0, 4'd3}   // 23 R3 timeout
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic heartbeatIn = 1'b0;
  logic hbFloating = 1'b0;
  logic sysReset = 1'b0;
  logic supplyOk = 1'b1;
  logic wdogN;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbwd_top #(
    .TICK_DIV(DIV), .TIMEOUT_TICKS(TICKS), .SYNC_STAGES(SYNC)
  ) u_hbwd_top (
    .clk(clk), .rstN(rstN), .heartbeatIn(heartbeatIn), .hbFloating(hbFloating),
    .sysReset(sysReset), .supplyOk(supplyOk), .wdogN(wdogN)
  );

  task automatic check(input string what, input int req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: wdogN=%b expected %b", req, what, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired: bench hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R8 reset state
    @(negedge clk);
    #1 check("reset, supply good", 8, wdogN, 1'b1);
    supplyOk = 1'b0;
    #1 check("reset, supply low", 8, wdogN, 1'b0);
    supplyOk = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      hbFloating = VECS[i].flt;
      sysReset   = VECS[i].rst;
      supplyOk   = VECS[i].sup;
      if (VECS[i].tog) heartbeatIn = ~heartbeatIn;
      repeat (int'(VECS[i].waitCyc)) @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d", i), int'(VECS[i].req), wdogN, VECS[i].exp);
    end

    // R5 one-period pulse: both edges seen, timeout measured from the falling one
    heartbeatIn = 1'b1;
    @(negedge clk);
    heartbeatIn = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check("short pulse, before timeout", 5, wdogN, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("short pulse, timeout", 5, wdogN, 1'b0);

    // R8 block reset releases an expired output
    rstN = 1'b0;
    #1 check("block reset while expired", 8, wdogN, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    repeat (LAT + 5) @(posedge clk);
    @(negedge clk);
    check("idle after block reset", 8, wdogN, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule